// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer for a 10-bit successive-approximation converter. A 3-bit mode input chooses which one of six start sources may launch a conversion. Once started, the block spends one cycle tracking the input. It then resolves the result one bit at a time, from the most significant bit down. For each bit it presents a trial code on the DAC output and reads back a single comparator bit. The final code is held in a result register and pulses a done strobe.

Each finished result is also tested against two programmable thresholds, a lower bound and an upper bound. When the test holds, a sticky window flag is raised. A single-ended or differential setting decides whether the code is read as unsigned or as two's complement for that test. An enable input gates everything: while it is low the sequencer sits idle, and any conversion in progress is abandoned. The analog front end (input selection, track-and-hold, comparator) lies outside the block. It is reached only through the comparator input and the DAC code output.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and win_flag_o are 0, result_o is 0 and dac_code_o is 0.
- R2: The mode field trig_mode_i chooses the start source: 0 = conv_start_wr_i, 1 = tmr0_ovf_i, 2 = tmr2_ovf_i, 3 = tmr1_ovf_i, 4 = ext_start_i, 5 = tmr3_ovf_i. A high level on the selected source while idle starts a conversion. Every other source is ignored.
- R3: Mode codes 6 and 7 never start a conversion, whatever the sources do.
- R4: busy_o rises on the clock edge that samples a valid start. It stays high for exactly 11 cycles: 1 track cycle and 10 bit cycles. Start requests that arrive while busy_o is high are dropped, and they do not launch a conversion later.
- R5: The bits are resolved from MSB to LSB. A trial bit is kept when cmp_i is 1 at the end of its cycle, which means the input is at or above the trial level. With an ideal comparator, result_o equals the input code.
- R6: done_o is high for exactly one cycle, on the same edge where busy_o falls and result_o takes the new code. result_o does not change at any other time.
- R7: While en_i is 0, no start source has any effect. Dropping en_i during a conversion returns busy_o to 0 on the next edge. In that case done_o stays low and result_o keeps its previous value.
- R8: When the lower bound win_gt_i is less than or equal to the upper bound win_lt_i, the flag is set for a result r with win_gt_i <= r <= win_lt_i (both ends included).
- R9: When win_gt_i is greater than win_lt_i, the flag is set for a result r with r > win_gt_i or r < win_lt_i (both ends excluded).
- R10: When diff_mode_i is 1, the result and both bounds are compared as 10-bit two's complement numbers. When it is 0, they are compared as unsigned numbers.
- R11: win_flag_o stays at 1 until win_clr_i is pulsed. If a clear and a hitting result arrive in the same cycle, the flag ends up at 1.
- R12: dac_code_o is 0 while idle and during the track cycle. During the cycle that tests bit k, it shows the bits already kept with bit k also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; 0 = shutdown |
| trig_mode_i | input | 3 | Start source select |
| conv_start_wr_i | input | 1 | Software start strobe |
| tmr0_ovf_i | input | 1 | Timer 0 overflow |
| tmr1_ovf_i | input | 1 | Timer 1 overflow |
| tmr2_ovf_i | input | 1 | Timer 2 overflow |
| tmr3_ovf_i | input | 1 | Timer 3 overflow |
| ext_start_i | input | 1 | External start input |
| diff_mode_i | input | 1 | 1 = differential (signed) compare |
| win_gt_i | input | 10 | Window lower bound |
| win_lt_i | input | 10 | Window upper bound |
| win_clr_i | input | 1 | Clear the window flag |
| cmp_i | input | 1 | Comparator: 1 when input >= DAC level |
| dac_code_o | output | 10 | Trial code for the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 10 | Last completed result |
| win_flag_o | output | 1 | Sticky window flag |

## Verification
Two situations are the hardest to reach from the ports. The first is the signed/unsigned difference in the window test. Because the out-of-order case wraps around, most threshold pairs give the same flag in both modes. A difference only appears when a pair is in order under one reading and reversed under the other, with the result sitting exactly on an endpoint. The bench therefore uses bounds 0x1F0 and 0x210 with a result of 0x1F0 and expects opposite flags in the two modes. The second is the collision of a clear with a hit. The bench counts cycles from the start so that win_clr_i is high on exactly the edge that finishes the conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TRACK, ST_CONV} sar_state_e;

  localparam int unsigned TRIG_W     = 3;
  localparam int unsigned N_TRIG_SRC = 6;
  // source slot index equals the mode code that selects it
  localparam int unsigned SRC_SW  = 0;
  localparam int unsigned SRC_T0  = 1;
  localparam int unsigned SRC_T2  = 2;
  localparam int unsigned SRC_T1  = 3;
  localparam int unsigned SRC_EXT = 4;
  localparam int unsigned SRC_T3  = 5;
endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
  import sar_pkg::*;
(
  input  logic [TRIG_W-1:0]     mode_i,
  input  logic [N_TRIG_SRC-1:0] src_i,
  output logic                  start_o
);
  localparam int unsigned N_CODE = 1 << TRIG_W;

  logic [N_CODE-1:0] hit;

  for (genvar g = 0; g < N_CODE; g++) begin : g_code
    if (g < N_TRIG_SRC) begin : g_live
      assign hit[g] = (mode_i == TRIG_W'(g)) & src_i[g];
    end else begin : g_rsvd
      assign hit[g] = 1'b0;
    end
  end

  assign start_o = |hit;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] res_o,
  output logic             fin_o,
  output logic [RES_W-1:0] fin_code_o
);
  localparam int unsigned BIT_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [BIT_W-1:0] MSB_IDX = BIT_W'(RES_W - 1);

  sar_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] kept;

  assign trial = RES_W'(1) << bit_q;
  // bits below bit_q are still zero, so OR builds the trial and the kept value
  assign kept       = cmp_i ? (code_q | trial) : code_q;
  assign fin_o      = en_i && (state_q == ST_CONV) && (bit_q == '0);
  assign fin_code_o = kept;
  assign dac_o      = (state_q == ST_CONV) ? (code_q | trial) : '0;
  assign busy_o     = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      code_q  <= '0;
      res_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        code_q  <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) state_q <= ST_TRACK;
          ST_TRACK: begin
            state_q <= ST_CONV;
            bit_q   <= MSB_IDX;
            code_q  <= '0;
          end
          ST_CONV: begin
            code_q <= kept;
            if (bit_q == '0) begin
              state_q <= ST_IDLE;
              res_o   <= kept;
              done_o  <= 1'b1;
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_win_cmp.sv
module sar_win_cmp #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             diff_i,
  input  logic [RES_W-1:0] gt_i,
  input  logic [RES_W-1:0] lt_i,
  input  logic             clr_i,
  input  logic             fin_i,
  input  logic [RES_W-1:0] code_i,
  output logic             flag_o
);
  localparam int unsigned EXT_W = RES_W + 1;

  logic signed [EXT_W-1:0] r_s, g_s, l_s;
  logic ordered, hit;

  // sign-extend in differential mode, zero-extend otherwise
  assign r_s = $signed({diff_i & code_i[RES_W-1], code_i});
  assign g_s = $signed({diff_i & gt_i[RES_W-1], gt_i});
  assign l_s = $signed({diff_i & lt_i[RES_W-1], lt_i});

  assign ordered = (g_s <= l_s);
  assign hit = ordered ? ((r_s >= g_s) && (r_s <= l_s))
                       : ((r_s >  g_s) || (r_s <  l_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_o <= 1'b0;
    else if (fin_i && hit)  flag_o <= 1'b1;
    else if (clr_i)         flag_o <= 1'b0;
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        trig_mode_i,
  input  logic              conv_start_wr_i,
  input  logic              tmr0_ovf_i,
  input  logic              tmr1_ovf_i,
  input  logic              tmr2_ovf_i,
  input  logic              tmr3_ovf_i,
  input  logic              ext_start_i,
  input  logic              diff_mode_i,
  input  logic [RES_W-1:0]  win_gt_i,
  input  logic [RES_W-1:0]  win_lt_i,
  input  logic              win_clr_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic              win_flag_o
);
  logic [N_TRIG_SRC-1:0] src;
  logic                  start, fin;
  logic [RES_W-1:0]      fin_code;

  always_comb begin
    src          = '0;
    src[SRC_SW]  = conv_start_wr_i;
    src[SRC_T0]  = tmr0_ovf_i;
    src[SRC_T2]  = tmr2_ovf_i;
    src[SRC_T1]  = tmr1_ovf_i;
    src[SRC_EXT] = ext_start_i;
    src[SRC_T3]  = tmr3_ovf_i;
  end

  sar_trig_sel u_trig (
    .mode_i (trig_mode_i),
    .src_i  (src),
    .start_o(start)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .start_i   (start),
    .cmp_i     (cmp_i),
    .dac_o     (dac_code_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .res_o     (result_o),
    .fin_o     (fin),
    .fin_code_o(fin_code)
  );

  sar_win_cmp #(.RES_W(RES_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .diff_i(diff_mode_i),
    .gt_i  (win_gt_i),
    .lt_i  (win_lt_i),
    .clr_i (win_clr_i),
    .fin_i (fin),
    .code_i(fin_code),
    .flag_o(win_flag_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [2:0]       trig_mode_i,
  input logic             win_clr_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic             win_flag_o
);
  a_r3_rsvd_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && trig_mode_i[2:1] == 2'b11) |=> !busy_o);

  a_r7_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r6_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_flag_o && !win_clr_i) |=> win_flag_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .trig_mode_i(trig_mode_i),
  .win_clr_i  (win_clr_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .win_flag_o (win_flag_o)
);

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [5:0] src = '0;   // slot k = source selected by mode code k
  logic       diff = 1'b0;
  logic [9:0] gt = '0, lt = '0, vin = '0;
  logic       clr = 1'b0;
  logic [9:0] dac, result;
  logic       busy, done, flag, cmp;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign cmp = (vin >= dac);  // ideal comparator model

  sar_conv_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .trig_mode_i(mode),
    .conv_start_wr_i(src[0]), .tmr0_ovf_i(src[1]), .tmr2_ovf_i(src[2]),
    .tmr1_ovf_i(src[3]), .ext_start_i(src[4]), .tmr3_ovf_i(src[5]),
    .diff_mode_i(diff), .win_gt_i(gt), .win_lt_i(lt), .win_clr_i(clr),
    .cmp_i(cmp), .dac_code_o(dac), .busy_o(busy), .done_o(done),
    .result_o(result), .win_flag_o(flag)
  );

  // diff, vin, gt, lt, expected flag
  localparam logic [31:0] VEC [11] = '{
    {1'b0, 10'd512,  10'd100,  10'd600,  1'b1},
    {1'b0, 10'd700,  10'd100,  10'd600,  1'b0},
    {1'b0, 10'd100,  10'd100,  10'd600,  1'b1},
    {1'b0, 10'd600,  10'd100,  10'd600,  1'b1},
    {1'b0, 10'd50,   10'd600,  10'd100,  1'b1},
    {1'b0, 10'd300,  10'd600,  10'd100,  1'b0},
    {1'b0, 10'd1023, 10'd600,  10'd100,  1'b1},
    {1'b0, 10'd600,  10'd600,  10'd100,  1'b0},
    {1'b0, 10'h1F0,  10'h1F0,  10'h210,  1'b1},
    {1'b1, 10'h1F0,  10'h1F0,  10'h210,  1'b0},
    {1'b1, 10'h3F0,  10'h3E0,  10'h010,  1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int slot);
    src[slot] = 1'b1;
    @(negedge clk);
    src[slot] = 1'b0;
  endtask

  task automatic conv(input int slot, output int cyc);
    pulse(slot);
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic wclear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [9:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 result", result, 0); chk("R1 flag", flag, 0); chk("R1 dac", dac, 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);

    // table: R5 result, R8/R9/R10 window
    foreach (VEC[i]) begin
      diff = VEC[i][31]; vin = VEC[i][30:21]; gt = VEC[i][20:11]; lt = VEC[i][10:1];
      wclear();
      conv(0, cyc);
      chk("R4 busy length", cyc, 11);
      chk("R6 done at end", done, 1);
      chk("R5 result", result, VEC[i][30:21]);
      chk(i < 4 ? "R8 window" : (i < 8 ? "R9 window" : "R10 window"), flag, VEC[i][0]);
    end
    diff = 1'b0;

    // R6 one-cycle done, result hold
    held = result;
    @(negedge clk);
    chk("R6 done width", done, 0);
    vin = 10'd5;
    repeat (5) @(negedge clk);
    chk("R6 result hold", result, held);

    // R2 each mode, wrong source ignored
    for (int m = 0; m < 6; m++) begin
      mode = 3'(m);
      pulse((m + 1) % 6);
      chk("R2 other source ignored", busy, 0);
      pulse(m);
      chk("R2 selected source starts", busy, 1);
      while (busy) @(negedge clk);
    end

    // R3 reserved codes
    for (int m = 6; m < 8; m++) begin
      mode = 3'(m);
      src = 6'h3F; @(negedge clk); src = '0;
      chk("R3 reserved no start", busy, 0);
      @(negedge clk);
      chk("R3 reserved still idle", busy, 0);
    end
    mode = 3'd0;

    // R4 retrigger while busy
    vin = 10'd300;
    pulse(0);
    cyc = 0;
    while (busy && cyc < 40) begin
      src[0] = (cyc == 3);
      cyc++;
      @(negedge clk);
    end
    src[0] = 1'b0;
    chk("R4 length with retrigger", cyc, 11);
    @(negedge clk);
    chk("R4 retrigger dropped", busy, 0);

    // R12 DAC trial codes
    vin = 10'd1023;
    pulse(0);
    chk("R12 track dac", dac, 0);
    @(negedge clk); chk("R12 bit9 trial", dac, 10'h200);
    @(negedge clk); chk("R12 bit8 trial kept", dac, 10'h300);
    while (busy) @(negedge clk);
    chk("R12 idle dac", dac, 0);
    vin = 10'd0;
    pulse(0);
    @(negedge clk); chk("R12 bit9 trial low", dac, 10'h200);
    @(negedge clk); chk("R12 bit8 trial dropped", dac, 10'h100);
    while (busy) @(negedge clk);
    chk("R5 zero input", result, 0);

    // R7 shutdown
    held = result;
    en = 1'b0;
    pulse(0);
    chk("R7 disabled ignores start", busy, 0);
    en = 1'b1; vin = 10'd77;
    pulse(0);
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R7 abort busy", busy, 0);
    chk("R7 abort no done", done, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 abort result kept", result, held);

    // R11 sticky, clear, clear vs set
    gt = 10'd100; lt = 10'd600; vin = 10'd200;
    wclear();
    conv(0, cyc);
    chk("R11 set", flag, 1);
    vin = 10'd900;
    conv(0, cyc);
    chk("R11 sticky over miss", flag, 1);
    wclear();
    chk("R11 cleared", flag, 0);
    vin = 10'd200;
    pulse(0);
    repeat (10) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R11 done with clear", done, 1);
    chk("R11 set wins over clear", flag, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule